// File: doc/BRIEF.md
# Fractional-Rate Microsecond Timebase

This block keeps a free-running microsecond count for a chip whose reference clock is not an integer multiple of 1 MHz. A fractional prescaler sits in front of the counter. On each enabled reference cycle the prescaler adds a step to an accumulator. When the accumulator reaches the modulus, the prescaler subtracts the modulus and issues one count enable. This gives an exact long-term rate of reference × step / modulus. With that rate set to 1 MHz, the counter advances once per microsecond at reference frequencies such as 12.8, 19.2 or 38.4 MHz.

Software reads the count through a small synchronous register port and sets the ratio through a 16-bit configuration word. Both fields of the configuration word are stored as value minus one. An external clock-enable input gates all timing activity. The count wraps silently, and software extends it to 64 bits.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads 0 and the configuration reads 0x000C, which divides the reference by 13.
- R2: Reads are combinational on byte address `addr_i`. Offset 0 returns the count, zero-extended to 32 bits. Offset 4 returns the configuration in bits 15:0, with bits 31:16 zero. Every other offset returns 0.
- R3: Configuration bits 15:8 hold step−1 and bits 7:0 hold modulus−1. When step < modulus, N enabled cycles after the last clear the count has advanced by exactly floor(N·step/modulus). For example, 0x043F gives 5 ticks per 64 cycles, 0x04BF gives 5 per 192, 0x000B gives 1 per 12, and 0x002F gives 1 per 48.
- R4: When step ≥ modulus, the count advances by one on every enabled cycle.
- R5: While `clk_en_i` is low, neither the count nor the prescaler phase changes.
- R6: A write to offset 4 loads bits 15:0 into the configuration and clears the prescaler accumulator. In that cycle the count does not change, even if a tick was due.
- R7: Writes to offset 0 and to unmapped offsets have no effect on the count, the configuration or the prescaler phase.
- R8: The count wraps from 2^CNT_W−1 to 0 with no flag.
- R9: The count changes by at most +1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Timer clock enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address within the register window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |

## Verification
A configuration write and a due prescaler tick can land on the same reference cycle. The block then has to suppress the tick and restart the phase. The bench provokes this by writing the configuration while a step-equals-modulus setting makes every cycle a tick cycle. It also writes in the middle of fractional runs. A scoreboard model rebases its count on each write and predicts floor(N·step/modulus) from that point on. Each read of the count is judged against that prediction, so a tick that leaks through the write cycle shows up as a count one too high.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned CFG_W   = 2 * FIELD_W;
  localparam logic [CFG_W-1:0] CFG_RST = 16'h000C;
  localparam int unsigned OFS_COUNT = 0;
  localparam int unsigned OFS_CFG   = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] step_m1;
    logic [FIELD_W-1:0] mod_m1;
  } tb_cfg_t;
endpackage

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [FIELD_W-1:0] step_m1_i,
  input  logic [FIELD_W-1:0] mod_m1_i,
  output logic               tick_o
);
  localparam int unsigned ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc_q, step, modu, sum;
  logic             sat, wrap;

  assign step = ACC_W'(step_m1_i) + ACC_W'(1);
  assign modu = ACC_W'(mod_m1_i) + ACC_W'(1);
  assign sum  = acc_q + step;
  assign sat  = step >= modu;
  assign wrap = sum >= modu;

  assign tick_o = en_i & ~clr_i & (sat | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (en_i) begin
      if (sat)         acc_q <= '0;
      else if (wrap)   acc_q <= sum - modu;
      else             acc_q <= sum;
    end
  end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/timebase_regs.sv
module timebase_regs
  import usec_timebase_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output tb_cfg_t           cfg_o,
  output logic              cfg_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit_cnt, hit_cfg;

  assign hit_cnt  = addr_i == ADDR_W'(OFS_COUNT);
  assign hit_cfg  = addr_i == ADDR_W'(OFS_CFG);
  assign cfg_wr_o = we_i & hit_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_o <= tb_cfg_t'(CFG_RST);
    else if (cfg_wr_o) cfg_o <= tb_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cnt)      rdata_o = DATA_W'(cnt_i);
    else if (hit_cfg) rdata_o = DATA_W'(cfg_o);
  end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_timebase_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  tb_cfg_t          cfg_q;
  logic             cfg_wr, tick;
  logic [CNT_W-1:0] cnt_q;

  timebase_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cnt_i    (cnt_q),
    .cfg_o    (cfg_q),
    .cfg_wr_o (cfg_wr),
    .rdata_o
  );

  frac_prescaler #(.FIELD_W(FIELD_W)) u_presc (
    .clk_i, .rst_ni,
    .en_i      (clk_en_i),
    .clr_i     (cfg_wr),
    .step_m1_i (cfg_q.step_m1),
    .mod_m1_i  (cfg_q.mod_m1),
    .tick_o    (tick)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i (tick),
    .cnt_o (cnt_q)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       wdata_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [15:0]       cfg_i,
  input logic              tick_i
);
  // R5
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(cnt_i));

  // R6
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(4)) |=> cfg_i == $past(wdata_i));

  // R6
  cfg_wr_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(4)) |=> $stable(cnt_i));

  // R7
  cfg_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(4)) |=> $stable(cfg_i));

  // R9
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i == $past(cnt_i)) || (cnt_i == CNT_W'($past(cnt_i) + CNT_W'(1))));

  // R4
  sat_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !(we_i && addr_i == ADDR_W'(4)) && cfg_i[15:8] >= cfg_i[7:0]) |-> tick_i);
endmodule

bind usec_timebase usec_timebase_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_en_i (clk_en_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i[15:0]),
  .cnt_i    (cnt_q),
  .cfg_i    (cfg_q),
  .tick_i   (tick)
);

// File: tb/usec_timebase_test.sv
`timescale 1ns/1ps
module usec_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_w;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  usec_timebase uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  usec_timebase #(.CNT_W(8)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(1'b1), .we_i(1'b0),
    .addr_i(4'h0), .wdata_i(32'h0), .rdata_o(rdata_w)
  );

  // reference model
  longint unsigned base, nen, nw;
  longint unsigned m_step, m_mod;
  logic [15:0] m_cfg;

  function automatic logic [31:0] cur();
    longint unsigned a;
    a = (m_step >= m_mod) ? nen : (nen * m_step) / m_mod;
    return 32'(base + a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base = 0; nen = 0; nw = 0;
      m_cfg = 16'h000C; m_step = 1; m_mod = 13;
    end else begin
      nw = nw + 1;
      if (we && addr == 4'h4) begin
        base = cur(); nen = 0;
        m_cfg = wdata[15:0];
        m_step = longint'(wdata[15:8]) + 1;
        m_mod  = longint'(wdata[7:0]) + 1;
      end else if (en) nen = nen + 1;
    end
  end

  // scoreboard
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h exp %h", it.tag, rdata, it.exp);
      end
    end
  end

  // R8 wrap on 8-bit instance, divide by 13 from reset
  always @(negedge clk) begin
    if (rst_n && (nw == 256*13 - 1 || nw == 256*13)) begin
      logic [31:0] e;
      e = 32'((nw / 13) % 256);
      n_run++;
      if (rdata_w !== e) begin
        n_fail++;
        $display("FAIL R8 wrap: got %h exp %h", rdata_w, e);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    item_t it;
    cyc(); we = 1'b0; addr = a;
    #0;
    if (a == 4'h0)      it.exp = cur();
    else if (a == 4'h4) it.exp = {16'h0, m_cfg};
    else                it.exp = 32'h0;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(); we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin cyc(); we = 1'b0; end
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(4'h0, "R1 count reset");
    rd(4'h4, "R1 cfg reset");
    rd(4'h8, "R2 unmapped read");
    rd(4'hC, "R2 unmapped read");
    en = 1'b1;
    idle(100);
    rd(4'h0, "R3 default div13");
    // R3 fractional 5/64 over long run
    wr(4'h4, 32'h0000_043F);
    rd(4'h4, "R6 cfg readback");
    idle(6400);
    rd(4'h0, "R3 0x043F long run");
    idle(37);
    rd(4'h0, "R3 0x043F mid phase");
    wr(4'h4, 32'hFFFF_04BF);
    rd(4'h4, "R2 cfg upper bits zero");
    idle(1000);
    rd(4'h0, "R3 0x04BF");
    wr(4'h4, 32'h0000_000B);
    idle(250);
    rd(4'h0, "R3 0x000B");
    wr(4'h4, 32'h0000_002F);
    idle(500);
    rd(4'h0, "R3 0x002F");
    // R4 step >= modulus
    wr(4'h4, 32'h0000_0500);
    idle(20);
    rd(4'h0, "R4 saturate");
    rd(4'h0, "R9 one step per cycle");
    // R5 enable low holds count and phase
    wr(4'h4, 32'h0000_0007);
    idle(5);
    en = 1'b0;
    idle(40);
    rd(4'h0, "R5 hold while disabled");
    en = 1'b1;
    idle(3);
    rd(4'h0, "R5 phase kept after enable");
    // R6 write in a tick cycle
    wr(4'h4, 32'h0000_0000);
    idle(10);
    wr(4'h4, 32'h0000_0000);
    rd(4'h0, "R6 tick suppressed on cfg write");
    wr(4'h4, 32'h0000_0102);
    idle(4);
    wr(4'h4, 32'h0000_0102);
    idle(2);
    rd(4'h0, "R6 phase cleared");
    // R7 ignored writes
    idle(1);
    wr(4'h0, 32'h1234_5678);
    rd(4'h0, "R7 count write ignored");
    wr(4'h8, 32'h0000_00FF);
    rd(4'h4, "R7 unmapped write ignored");
    idle(7);
    rd(4'h0, "R7 phase kept");
    while (nw < 256*13 + 4) idle(1);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule